// File: doc/BRIEF.md
# Four-Level Nested Interrupt Priority Controller

This block sits beside a small 8-bit CPU core and decides which of seven interrupt sources the core serves next. The seven sources are two external pins, two timer overflows, an I2C unit, a serial port and a third timer. Each source has its own enable bit, and one global enable gates all of them. Each source also gets a 2-bit priority level, made from one bit in a low-priority register and one bit in a high-priority register. The block captures the request flags it owns. Once per clock it registers the winning pending request, then shows the core a request line, the winner's vector address and its level.

The core answers with a one-cycle acknowledge when it takes the vector, and with a one-cycle return strobe when the handler ends. A 4-bit in-service mask, one bit per level, follows those strobes. Because of this mask, a request at a higher level can interrupt a running handler, while a request at the same or a lower level waits.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0, `isr_mask` is 0 and every register reads back as 0.
- R2: While global enable (bit 7 of the enable register) is 0, no request is raised. While it is 1, a source is only considered when its own enable bit is 1.
- R3: A source's level is {high bit, low bit}, taken from the low and high priority registers at the bit index of the source's polling position. That index is 0 ext0, 1 I2C, 2 timer 0, 3 ext1, 4 timer 1, 5 serial, 6 timer 2. The highest pending level wins, whatever the polling order.
- R4: Among pending sources at the winning level, the lowest polling index wins (ext0 first, timer 2 last).
- R5: `irq_vector` is 0x03 for ext0, 0x2B for I2C, 0x0B for timer 0, 0x13 for ext1, 0x1B for timer 1, 0x23 for serial and 0x3B for timer 2.
- R6: The enable register (address 0) holds global enable in bit 7, timer 2 in bit 5, serial in bit 4, timer 1 in bit 3, ext1 in bit 2, timer 0 in bit 1 and ext0 in bit 0. Bit 6 is not stored and reads 0. The I2C enable is bit 0 of address 3. The low priority register is address 1 and the high priority register is address 2.
- R7: `irq_req` is 1 only when the winner's level is strictly above every level set in `isr_mask`. A request at an equal or lower level waits until a return clears the blocking level.
- R8: A higher-level request is raised while a lower level is in service. After its return, only the highest in-service bit clears, so the lower level stays in service.
- R9: An acknowledge while `irq_req` is 1 sets the `isr_mask` bit of `irq_level`. Only an acknowledge sets a bit, and `irq_reti` clears the highest set bit.
- R10: Acknowledge clears the timer 0 and timer 1 flags, and clears an external flag only in edge mode. A level-mode external source, and the I2C, serial and timer 2 inputs, request again after the return while they remain active.
- R11: While `irq_req` is 1 and no acknowledge arrives, `irq_req`, `irq_vector` and `irq_level` hold their values, even if new requests arrive or old ones drop.
- R12: When a timer overflow pulse is sampled at clock edge k, `irq_req` rises after edge k+1.
- R13: External pins are active low and pass through a two-flop synchronizer. In edge mode (`ext_edge` bit 1) a high-to-low transition sets the flag. In level mode a low pin requests directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| ext_n | input | 2 | External interrupt pins, active low |
| ext_edge | input | 2 | Per external pin: 1 edge mode, 0 level mode |
| tmr_ovf | input | 2 | Timer 0/1 overflow pulses |
| per_req | input | 3 | Held requests: I2C, serial, timer 2 |
| irq_ack | input | 1 | Core took the presented vector |
| irq_reti | input | 1 | Core returned from a handler |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vector | output | 8 | Vector address of the presented source |
| irq_level | output | 2 | Level of the presented source |
| isr_mask | output | 4 | In-service levels, one bit per level |

## Verification
A corrupted in-service mask shows up on `isr_mask` in the cycle right after the acknowledge or return that caused it. It also shows at the request line within two cycles, because a request that should be raised stays low, or one at a blocked level appears. A wrong winner register shows as a wrong vector or level at the moment `irq_req` rises. A flag that is not cleared shows as a repeated request about two cycles after the following return. A hold register that drifts changes the vector while the request is still pending, and the bench watches for exactly that.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int NSRC = 7;
  localparam int NLVL = 4;
  localparam int LVLW = $clog2(NLVL);
  localparam int IDXW = $clog2(NSRC);
  localparam int DW   = 8;

  typedef logic [LVLW-1:0] lvl_t;
  typedef logic [IDXW-1:0] idx_t;

  typedef struct packed {
    logic valid;
    lvl_t lvl;
  } lvl_pick_t;

  typedef enum logic [1:0] {
    RA_ENABLE   = 2'd0,
    RA_PRIO_LO  = 2'd1,
    RA_PRIO_HI  = 2'd2,
    RA_ENA_AUX  = 2'd3
  } reg_addr_e;

  // polling positions, lowest index wins a tie
  localparam idx_t SRC_EXT0 = 3'd0;
  localparam idx_t SRC_I2C  = 3'd1;
  localparam idx_t SRC_TMR0 = 3'd2;
  localparam idx_t SRC_EXT1 = 3'd3;
  localparam idx_t SRC_TMR1 = 3'd4;
  localparam idx_t SRC_SER  = 3'd5;
  localparam idx_t SRC_TMR2 = 3'd6;

  function automatic logic [DW-1:0] vector_of(input idx_t s);
    case (s)
      SRC_EXT0: vector_of = 8'h03;
      SRC_TMR0: vector_of = 8'h0B;
      SRC_EXT1: vector_of = 8'h13;
      SRC_TMR1: vector_of = 8'h1B;
      SRC_SER:  vector_of = 8'h23;
      SRC_I2C:  vector_of = 8'h2B;
      SRC_TMR2: vector_of = 8'h3B;
      default:  vector_of = 8'h00;
    endcase
  endfunction

  // highest set bit of a per-level mask
  function automatic lvl_pick_t top_of(input logic [NLVL-1:0] m);
    lvl_pick_t r;
    r = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (m[l]) begin
        r.valid = 1'b1;
        r.lvl   = lvl_t'(l);
      end
    end
    return r;
  endfunction

  function automatic logic [NLVL-1:0] level_bit(input lvl_t l);
    return NLVL'(1) << l;
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_nest_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [1:0]                 wr_addr,
  input  logic [DW-1:0]              wr_data,
  input  logic [1:0]                 rd_addr,
  output logic [DW-1:0]              rd_data,
  output logic [NSRC-1:0]            src_en,
  output logic [NSRC-1:0][LVLW-1:0]  src_lvl
);
  localparam logic [DW-1:0] ENA_MASK = 8'hBF;

  logic [DW-1:0]   ena_q;
  logic            aux_q;
  logic [NSRC-1:0] plo_q;
  logic [NSRC-1:0] phi_q;
  logic            glob_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q <= '0;
      aux_q <= 1'b0;
      plo_q <= '0;
      phi_q <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        RA_ENABLE:  ena_q <= wr_data & ENA_MASK;
        RA_PRIO_LO: plo_q <= wr_data[NSRC-1:0];
        RA_PRIO_HI: phi_q <= wr_data[NSRC-1:0];
        RA_ENA_AUX: aux_q <= wr_data[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr_e'(rd_addr))
      RA_ENABLE:  rd_data = ena_q;
      RA_PRIO_LO: rd_data = {1'b0, plo_q};
      RA_PRIO_HI: rd_data = {1'b0, phi_q};
      RA_ENA_AUX: rd_data = {7'd0, aux_q};
      default:    rd_data = '0;
    endcase
  end

  assign glob_en = ena_q[7];
  assign src_en  = glob_en ? {ena_q[5], ena_q[4], ena_q[3], ena_q[2],
                              ena_q[1], aux_q, ena_q[0]} : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_lvl
    assign src_lvl[i] = {phi_q[i], plo_q[i]};
  end
endmodule

// File: rtl/irq_flags.sv
module irq_flags
  import irq_nest_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      ext_n,
  input  logic [1:0]      ext_edge,
  input  logic [1:0]      tmr_ovf,
  input  logic [2:0]      per_req,
  input  logic [NSRC-1:0] clr_src,
  output logic [NSRC-1:0] req_vec
);
  logic [1:0] ext_req;
  logic [1:0] tmr_req;

  for (genvar e = 0; e < 2; e++) begin : g_ext
    localparam idx_t SI = (e == 0) ? SRC_EXT0 : SRC_EXT1;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   flag_q;
    logic                   pin_s;
    logic                   fall;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '1;
        prev_q <= 1'b1;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_n[e]};
        prev_q <= sync_q[SYNC_STAGES-1];
      end
    end

    assign pin_s = sync_q[SYNC_STAGES-1];
    assign fall  = prev_q & ~pin_s;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     flag_q <= 1'b0;
      else if (ext_edge[e] && fall)   flag_q <= 1'b1;
      else if (clr_src[SI] || !ext_edge[e]) flag_q <= 1'b0;
    end

    assign ext_req[e] = ext_edge[e] ? flag_q : ~pin_s;
  end

  for (genvar t = 0; t < 2; t++) begin : g_tmr
    localparam idx_t SI = (t == 0) ? SRC_TMR0 : SRC_TMR1;
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flag_q <= 1'b0;
      else if (tmr_ovf[t])  flag_q <= 1'b1;
      else if (clr_src[SI]) flag_q <= 1'b0;
    end

    assign tmr_req[t] = flag_q;
  end

  assign req_vec = {per_req[2], per_req[1], tmr_req[1], ext_req[1],
                    tmr_req[0], per_req[0], ext_req[0]};
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_nest_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hold,
  input  logic [NSRC-1:0]            pend,
  input  logic [NSRC-1:0][LVLW-1:0]  src_lvl,
  output logic                       win_valid_q,
  output idx_t                       win_idx_q,
  output lvl_t                       win_lvl_q
);
  logic best_valid;
  idx_t best_idx;
  lvl_t best_lvl;

  // descending scan with >= keeps the lowest index among the highest level
  always_comb begin
    best_valid = 1'b0;
    best_idx   = '0;
    best_lvl   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i] && (!best_valid || src_lvl[i] >= best_lvl)) begin
        best_valid = 1'b1;
        best_idx   = idx_t'(i);
        best_lvl   = src_lvl[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid_q <= 1'b0;
      win_idx_q   <= '0;
      win_lvl_q   <= '0;
    end else if (!hold) begin
      win_valid_q <= best_valid;
      win_idx_q   <= best_idx;
      win_lvl_q   <= best_lvl;
    end
  end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice
  import irq_nest_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  lvl_t            take_lvl,
  input  logic            reti,
  output logic [NLVL-1:0] isr_q,
  output lvl_pick_t       top
);
  logic [NLVL-1:0] drop_bit;
  logic [NLVL-1:0] set_bit;

  assign top      = top_of(isr_q);
  assign drop_bit = (reti && top.valid) ? level_bit(top.lvl) : '0;
  assign set_bit  = take ? level_bit(take_lvl) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= (isr_q & ~drop_bit) | set_bit;
  end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [1:0]  rd_addr,
  output logic [7:0]  rd_data,
  input  logic [1:0]  ext_n,
  input  logic [1:0]  ext_edge,
  input  logic [1:0]  tmr_ovf,
  input  logic [2:0]  per_req,
  input  logic        irq_ack,
  input  logic        irq_reti,
  output logic        irq_req,
  output logic [7:0]  irq_vector,
  output logic [1:0]  irq_level,
  output logic [3:0]  isr_mask
);
  logic [NSRC-1:0]           src_en;
  logic [NSRC-1:0][LVLW-1:0] src_lvl;
  logic [NSRC-1:0]           req_vec;
  logic [NSRC-1:0]           pend;
  logic [NSRC-1:0]           clr_src;
  logic                      win_valid_q;
  idx_t                      win_idx_q;
  lvl_t                      win_lvl_q;
  lvl_pick_t                 isr_top;
  logic                      above_isr;
  logic                      grant;
  logic                      hold;

  irq_regs u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .src_en, .src_lvl
  );

  irq_flags #(.SYNC_STAGES(2)) u_flags (
    .clk, .rst_n, .ext_n, .ext_edge, .tmr_ovf, .per_req, .clr_src, .req_vec
  );

  assign pend = req_vec & src_en;

  irq_arbiter u_arb (
    .clk, .rst_n, .hold, .pend, .src_lvl, .win_valid_q, .win_idx_q, .win_lvl_q
  );

  irq_inservice u_isr (
    .clk, .rst_n, .take(grant), .take_lvl(win_lvl_q), .reti(irq_reti),
    .isr_q(isr_mask), .top(isr_top)
  );

  assign above_isr  = !isr_top.valid || (win_lvl_q > isr_top.lvl);
  assign irq_req    = win_valid_q && above_isr;
  assign grant      = irq_req && irq_ack;
  assign hold       = irq_req && !irq_ack;
  assign clr_src    = grant ? (NSRC'(1) << win_idx_q) : '0;
  assign irq_vector = win_valid_q ? vector_of(win_idx_q) : '0;
  assign irq_level  = win_lvl_q;
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_req,
  input logic       irq_ack,
  input logic       irq_reti,
  input logic [7:0] irq_vector,
  input logic [1:0] irq_level,
  input logic [3:0] isr_mask
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vector) && $stable(irq_level))); // R11

  AST_REQ_ABOVE_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((isr_mask >> irq_level) == 4'd0)); // R7

  AST_VECTOR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vector inside {8'h03, 8'h0B, 8'h13, 8'h1B, 8'h23, 8'h2B, 8'h3B})); // R5

  AST_ACK_MARKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack && !irq_reti) |=> isr_mask[$past(irq_level)]); // R9

  AST_ISR_GROWS_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(isr_mask) > $countones($past(isr_mask))) |-> $past(irq_ack)); // R9

  AST_RETI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_reti && !irq_ack && (isr_mask != 4'd0))
      |=> ($countones(isr_mask) + 1 == $countones($past(isr_mask)))); // R8
endmodule

bind irq_nest_ctrl irq_nest_chk u_chk (
  .clk, .rst_n, .irq_req, .irq_ack, .irq_reti, .irq_vector, .irq_level, .isr_mask
);

// File: tb/irq_nest_ctrl_tb.sv
module irq_nest_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [1:0] ext_n = 2'b11;
  logic [1:0] ext_edge = 2'b00;
  logic [1:0] tmr_ovf = '0;
  logic [2:0] per_req = '0;
  logic       irq_ack = 1'b0;
  logic       irq_reti = 1'b0;
  logic       irq_req;
  logic [7:0] irq_vector;
  logic [1:0] irq_level;
  logic [3:0] isr_mask;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_nest_ctrl u_dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
  endtask

  task automatic reti();
    irq_reti = 1'b1; cyc(1); irq_reti = 1'b0;
  endtask

  task automatic pulse_tmr(input logic [1:0] which);
    tmr_ovf = which; cyc(1); tmr_ovf = '0;
  endtask

  task automatic expect_req(input string tag, input logic [7:0] vec, input logic [1:0] lvl);
    check({tag, " req"}, irq_req, 1'b1);
    check({tag, " vector"}, irq_vector, vec);
    check({tag, " level"}, irq_level, lvl);
  endtask

  task automatic t_reset();
    check("R1 req", irq_req, 1'b0);
    check("R1 isr", isr_mask, 4'd0);
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a); #0.1;
      check("R1 reg", rd_data, 8'h00);
    end
  endtask

  task automatic t_layout();
    wr(2'd0, 8'hFF);
    rd_addr = 2'd0; #0.1;
    check("R6 bit6 unused", rd_data, 8'hBF);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_enables();
    wr(2'd0, 8'h02);
    pulse_tmr(2'b01); cyc(4);
    check("R2 global off", irq_req, 1'b0);
    wr(2'd0, 8'h80); cyc(3);
    check("R2 source off", irq_req, 1'b0);
    wr(2'd0, 8'h82); cyc(3);
    expect_req("R2 t0", 8'h0B, 2'd0);
    ack();
    check("R9 isr after ack", isr_mask, 4'b0001);
    cyc(2);
    check("R7 same level blocked", irq_req, 1'b0);
    reti(); cyc(2);
    check("R10 t0 flag cleared", irq_req, 1'b0);
    check("R9 isr after reti", isr_mask, 4'd0);
  endtask

  task automatic t_latency();
    wr(2'd0, 8'h88);
    tmr_ovf = 2'b10; cyc(1); tmr_ovf = '0;
    check("R12 one edge", irq_req, 1'b0);
    cyc(1);
    check("R12 two edges", irq_req, 1'b1);
    check("R5 t1 vector", irq_vector, 8'h1B);
    ack(); reti(); cyc(2);
    check("R10 t1 cleared", irq_req, 1'b0);
  endtask

  task automatic t_levels();
    wr(2'd1, 8'h04);
    wr(2'd2, 8'h10);
    wr(2'd0, 8'h8A);
    pulse_tmr(2'b11); cyc(3);
    expect_req("R3 higher level", 8'h1B, 2'd2);
    ack();
    check("R9 level2 set", isr_mask, 4'b0100);
    cyc(2);
    check("R7 lower waits", irq_req, 1'b0);
    reti(); cyc(2);
    expect_req("R7 after return", 8'h0B, 2'd1);
    ack(); reti(); cyc(2);
    check("R10 both cleared", irq_req, 1'b0);
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
  endtask

  task automatic t_polling();
    wr(2'd0, 8'hB0); wr(2'd3, 8'h01);
    per_req = 3'b111; cyc(3);
    expect_req("R4 i2c first", 8'h2B, 2'd0);
    ack(); cyc(2);
    check("R7 tie blocked", irq_req, 1'b0);
    per_req[0] = 1'b0; reti(); cyc(2);
    expect_req("R4 serial next", 8'h23, 2'd0);
    ack(); per_req[1] = 1'b0; reti(); cyc(2);
    expect_req("R4 timer2 last", 8'h3B, 2'd0);
    ack(); per_req = '0; reti(); cyc(2);
    check("R10 peripherals idle", irq_req, 1'b0);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_preempt();
    wr(2'd0, 8'h98);
    wr(2'd1, 8'h10); wr(2'd2, 8'h10);
    per_req[1] = 1'b1; cyc(3);
    expect_req("R8 serial low", 8'h23, 2'd0);
    ack();
    check("R8 isr low", isr_mask, 4'b0001);
    pulse_tmr(2'b10); cyc(3);
    expect_req("R8 preempt", 8'h1B, 2'd3);
    ack();
    check("R8 nested isr", isr_mask, 4'b1001);
    reti();
    check("R8 resume lower", isr_mask, 4'b0001);
    cyc(2);
    check("R8 serial still blocked", irq_req, 1'b0);
    per_req = '0; reti();
    check("R8 all done", isr_mask, 4'd0);
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
  endtask

  task automatic t_external();
    wr(2'd0, 8'h85);
    ext_edge = 2'b01;
    ext_n[0] = 1'b0; cyc(6);
    expect_req("R13 edge ext0", 8'h03, 2'd0);
    ack(); reti(); cyc(3);
    check("R10 edge flag cleared", irq_req, 1'b0);
    ext_n[0] = 1'b1; cyc(3);
    ext_n[1] = 1'b0; cyc(5);
    expect_req("R13 level ext1", 8'h13, 2'd0);
    ack(); reti(); cyc(2);
    expect_req("R10 level not cleared", 8'h13, 2'd0);
    ext_n[1] = 1'b1; cyc(4);
    expect_req("R11 held after drop", 8'h13, 2'd0);
    ack(); reti(); cyc(2);
    check("R13 level released", irq_req, 1'b0);
  endtask

  task automatic t_hold();
    wr(2'd0, 8'h89);
    pulse_tmr(2'b10); cyc(3);
    expect_req("R11 t1 presented", 8'h1B, 2'd0);
    ext_n[0] = 1'b0; cyc(6);
    expect_req("R11 vector held", 8'h1B, 2'd0);
    ack(); ext_n[0] = 1'b1; cyc(2);
    check("R7 ext0 waits", irq_req, 1'b0);
    reti(); cyc(2);
    expect_req("R4 ext0 after", 8'h03, 2'd0);
    ack(); reti(); cyc(2);
    check("R9 final isr", isr_mask, 4'd0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_layout();
    t_enables();
    t_latency();
    t_levels();
    t_polling();
    t_preempt();
    t_external();
    t_hold();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule